// File: doc/BRIEF.md
# Serial Output Word Shifter

This block turns words taken from a FIFO into a bit stream on one serial output line. A slow serial shift clock drives it. The block samples that clock on its fast system clock and synchronises it. Each rising edge it detects moves the stream on by one bit, least significant bit first. When a word is finished, the block asks the FIFO core for the next word and captures that word in the same system-clock cycle.

A one-hot position bus shows which bit of the current word is on the line. The word width is set by wiring the word-end input back to one of these position lines: position 8 gives 9-bit words, position 7 gives 8-bit words, and so on. A word always ends after position 8.

For a cascade, the expansion input of the first device is held high. Each later device takes its expansion input from position 8 of the device before it. A device starts a new word only while its expansion input is high. An active-low output enable gates the serial line to its idle level and drives an enable flag for the pad.

Top module: `ser_out_shifter`

## Requirements
- R1: After reset the serial output is at the idle level (high), the position bus is all zero and no read request is issued.
- R2: The shift clock passes through a two-flop synchroniser and an edge detector. A rising edge first sampled at system edge k takes effect at system edge k+2, so outputs change after the third sampling edge. Falling edges and steady levels have no effect.
- R3: Bit i of a loaded word is on the serial output while position line i is high. A new word always starts at bit 0 (the LSB), with position line 0 high.
- R4: The position bus is one-hot while a word is active and all zero when idle. Each detected edge inside a word moves it up by one line.
- R5: A word boundary is a detected edge while the word-end input is high, while position line 8 is high, or while the block is idle. At a boundary the block captures the FIFO head word and raises the read request for exactly one system cycle.
- R6: The word width follows the position line fed back to the word-end input: a feedback from line n gives (n+1)-bit words.
- R7: At a boundary with the FIFO empty, no read request is issued and the block goes idle (output high, positions zero). It loads at the next detected edge once the FIFO is non-empty.
- R8: At a boundary with the expansion input low, no word is loaded and the block goes idle.
- R9: While the output enable (active low) is high, the serial output sits at the idle level and the enable flag is low. Shifting continues unseen, and the stream is visible again as soon as the enable returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| socp | input | 1 | Serial shift clock, asynchronous |
| sox | input | 1 | Expansion input; a word may start only while high |
| oe_n | input | 1 | Output enable, active low |
| fifo_empty | input | 1 | FIFO core has no word |
| rd_word | input | 9 | Head word of the FIFO core (show-ahead) |
| rd_strobe | input | 1 | Word-end feedback from a chosen position line |
| rd_req | output | 1 | One-cycle pop request to the FIFO core |
| pos | output | 9 | One-hot position of the bit on the line |
| so | output | 1 | Serial data output |
| so_en | output | 1 | Pad enable for the serial output |

## Verification
Every register result is due three system edges after the shift clock is first sampled high. The read request and the captured word appear on that same edge. The gating by the output enable is combinational and holds in the same cycle. The bench reference model keeps its own three-deep history of the sampled shift clock, so it fires at exactly that edge. All outputs are compared one nanosecond after each falling clock edge, after inputs settle and well before the next rising edge. A dedicated check also confirms that the position bus is still unchanged after two edges and has moved after the third.

// File: rtl/ser_out_shifter.sv
module ser_out_shifter #(
  parameter int W = 9,
  parameter bit IDLE_LEVEL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         socp,
  input  logic         sox,
  input  logic         oe_n,
  input  logic         fifo_empty,
  input  logic [W-1:0] rd_word,
  input  logic         rd_strobe,
  output logic         rd_req,
  output logic [W-1:0] pos,
  output logic         so,
  output logic         so_en
);

  logic [2:0]   sync;
  logic [W-1:0] shreg;
  logic         rise, idle, boundary;

  assign rise     = sync[1] & ~sync[2];
  assign idle     = ~|pos;
  assign boundary = rd_strobe | pos[W-1] | idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], socp};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      pos    <= '0;
      rd_req <= 1'b0;
    end else begin
      rd_req <= 1'b0;
      if (rise) begin
        if (!boundary) begin
          shreg <= shreg >> 1;
          pos   <= pos << 1;
        end else if (sox && !fifo_empty) begin
          shreg  <= rd_word;
          pos    <= {{(W-1){1'b0}}, 1'b1};
          rd_req <= 1'b1;
        end else begin
          pos <= '0;
        end
      end
    end
  end

  assign so_en = ~oe_n;
  assign so    = (so_en && !idle) ? shreg[0] : IDLE_LEVEL;

endmodule

module ser_out_shifter_chk #(
  parameter int W = 9
) (
  input logic         clk,
  input logic         rst_n,
  input logic         socp,
  input logic         sox,
  input logic         fifo_empty,
  input logic         rd_req,
  input logic [W-1:0] pos
);

  // R4
  pos_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pos));

  // R5
  rd_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  // R7
  empty_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !$past(fifo_empty));

  // R8
  sox_gates_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> $past(sox));

  // R3
  load_starts_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> pos[0]);

  // R2
  no_edge_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(socp, 3) |-> $stable(pos));

endmodule

bind ser_out_shifter ser_out_shifter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .socp(socp), .sox(sox),
  .fifo_empty(fifo_empty), .rd_req(rd_req), .pos(pos)
);

// File: tb/ser_out_shifter_test.sv
module ser_out_shifter_test;
  localparam int W = 9;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, socp, sox, oe_n, fifo_empty, rd_strobe;
  logic [W-1:0] rd_word;
  logic rd_req, so, so_en;
  logic [W-1:0] pos;

  int sel = 8;
  logic [W-1:0] q[$];
  int vectors = 0, fails = 0, cycles = 0;
  string phase = "R1";

  assign rd_strobe = pos[sel];

  ser_out_shifter uut (
    .clk(clk), .rst_n(rst_n), .socp(socp), .sox(sox), .oe_n(oe_n),
    .fifo_empty(fifo_empty), .rd_word(rd_word), .rd_strobe(rd_strobe),
    .rd_req(rd_req), .pos(pos), .so(so), .so_en(so_en)
  );

  task automatic refresh();
    fifo_empty = (q.size() == 0);
    rd_word    = (q.size() == 0) ? '0 : q[0];
  endtask

  task automatic push(input logic [W-1:0] w);
    q.push_back(w);
    refresh();
  endtask

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (phase %s) t=%0t actual=%0h expected=%0h", tag, phase, $time, act, exp);
    end
  endtask

  // reference model
  bit ms1, ms2, ms3, m_valid, m_rdreq;
  int m_idx;
  logic [W-1:0] m_word;

  always @(posedge clk) begin
    bit rise;
    if (!rst_n) begin
      ms1 = 0; ms2 = 0; ms3 = 0; m_valid = 0; m_rdreq = 0; m_idx = 0; m_word = '0;
    end else begin
      rise = ms2 && !ms3;
      ms3 = ms2; ms2 = ms1; ms1 = socp;
      m_rdreq = 0;
      if (rise) begin
        if (m_valid && m_idx != sel && m_idx != W-1) m_idx++;
        else if (sox && q.size() > 0) begin
          m_word = q[0]; m_idx = 0; m_valid = 1; m_rdreq = 1;
        end else m_valid = 0;
      end
    end
  end

  always @(negedge clk) begin
    #1;
    cycles++;
    if (rst_n) begin
      check("R3 so", so, (!oe_n && m_valid) ? int'(m_word[m_idx]) : 1);
      check("R4 pos", pos, m_valid ? (1 << m_idx) : 0);
      check("R5 rd_req", rd_req, m_rdreq);
      check("R9 so_en", so_en, !oe_n);
      if (m_rdreq) begin
        void'(q.pop_front());
        refresh();
      end
    end
  end

  task automatic pulses(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); socp = 1'b1;
      repeat (hi) @(negedge clk);
      socp = 1'b0;
      repeat (lo - 1) @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0; socp = 1'b0; sox = 1'b1; oe_n = 1'b0;
    refresh();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 so idle", so, 1);
    check("R1 pos zero", pos, 0);
    check("R1 rd_req low", rd_req, 0);

    phase = "R2";
    push(9'h1A5); push(9'h0F3);
    @(negedge clk); socp = 1'b1;
    @(negedge clk); #1; check("R2 no move after 1 edge", pos, 0);
    @(negedge clk); #1; check("R2 no move after 2 edges", pos, 0);
    @(negedge clk); #1; check("R2 moved after 3 edges", pos, 1);
    socp = 1'b0;
    repeat (6) @(negedge clk);
    #1; check("R2 falling edge and level ignored", pos, 1);

    phase = "R3 R6 9-bit";
    push(9'h155); push(9'h0AA); push(9'h101);
    pulses(50, 4, 4);

    phase = "R6 8-bit";
    sel = 7;
    push(9'h1FF); push(9'h080); push(9'h03C);
    pulses(30, 3, 5);

    phase = "R6 4-bit";
    sel = 3;
    push(9'h00F); push(9'h005); push(9'h00A); push(9'h1F9);
    pulses(22, 2, 2);

    phase = "R7 empty then resume";
    pulses(4, 3, 3);
    push(9'h0C7);
    pulses(8, 3, 3);

    phase = "R8 sox low";
    sel = 8;
    pulses(10, 3, 3);
    sox = 1'b0;
    push(9'h123); push(9'h0DE);
    pulses(6, 3, 3);
    sox = 1'b1;
    pulses(12, 3, 3);

    phase = "R9 output disabled";
    push(9'h16B); push(9'h094);
    pulses(4, 3, 3);
    oe_n = 1'b1;
    pulses(5, 3, 3);
    oe_n = 1'b0;
    pulses(12, 1, 1);

    repeat (10) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired t=%0t actual=running expected=done", $time);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule